// File: doc/BRIEF.md
# Deep Sleep Entry Sequencer

This block runs the hardware side of a software request to put the chip into a deep low-power state. It leaves the active mode on a one-cycle request pulse. It raises a busy indication, freezes the control registers and holds off new clock and user reset requests. It then looks at the clock requests that are still pending. Only a small, fixed set of clocks may stay alive in deep sleep.

If a clock outside that set is still requested and the override input is low, entry is refused. A sticky invalid-clock flag is raised and the block does not start the supply handshake. Where it goes next depends on the flag's interrupt enable:

- enable high: it pulses an interrupt and goes straight back to active;
- enable low: it parks in light sleep.

If entry is allowed, the block asks an external supply controller to adjust and waits for its acknowledge. It then unfreezes everything and reports the deep mode. The deep mode is the deeper of the two variants when both the real-time-clock and the watchdog enable inputs are low.

Any sleep state is left on a peripheral interrupt or on a qualified pin event. A pin event qualifies only when the pin is in plain GPIO function and its interrupt enable is set. The mode identifier captured at request time is reported as the mode to resume.

Top module: `lpm_entry_seq`

## Requirements
- R1: When `entry_req` is high while the block is active and not busy, from the next cycle `busy`, `reg_lock` and `req_hold` are high, and `resume_mode` holds the `active_mode_id` value sampled with the request.
- R2: An `entry_req` that arrives while `busy` is high, or while in a sleep mode, is ignored, and `resume_mode` keeps its value.
- R3: Clock requests on bits 0 and 1 of `clk_req` are allowed in deep sleep, and any other set bit is a violation. A violation with `force_entry` low sets `inv_clk_flag` two cycles after the request is taken, and `supply_req` never rises for that request.
- R4: With no violation, or with `force_entry` high, `supply_req` rises two cycles after the request is taken and `inv_clk_flag` is not set.
- R5: The deep mode entered is LP4 (code 3) when `rtc_en` and `wdt_en` are both low at the clock check, and LP3 (code 2) otherwise.
- R6: `supply_req` stays high until `supply_ack` is sampled high, for any number of cycles, and `busy` stays high throughout. In the cycle after the acknowledge, `pwr_mode` shows the deep mode and `busy`, `reg_lock`, `req_hold` and `supply_req` are low.
- R7: A refused entry with `inv_clk_ie` low leaves the block in LP0 (code 1) with `busy` low.
- R8: A refused entry with `inv_clk_ie` high pulses `inv_clk_irq` for exactly one cycle and returns to ACTIVE (code 0) with `busy` low.
- R9: `inv_clk_flag` stays set through wakeups and further cycles until a cycle with `inv_clk_clr` high, after which it reads 0.
- R10: In LP0, LP3 or LP4, a high `periph_irq` or a qualified pin event returns `pwr_mode` to ACTIVE in the next cycle, with `resume_mode` equal to the value captured at the request.
- R11: A pin event on bit i wakes the block only if `pin_sel0[i]` and `pin_sel1[i]` are both 0 and `pin_ie[i]` is 1. Otherwise `pwr_mode` is unchanged.
- R12: After reset `pwr_mode` is ACTIVE (0), and `busy`, `reg_lock`, `req_hold`, `supply_req`, `inv_clk_flag` and `inv_clk_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_req | input | 1 | Software request to enter deep sleep (pulse) |
| active_mode_id | input | 2 | Identifier of the current active mode |
| force_entry | input | 1 | Override that ignores clock violations |
| inv_clk_ie | input | 1 | Interrupt enable for the invalid-clock flag |
| inv_clk_clr | input | 1 | Write-one-to-clear strobe for the invalid-clock flag |
| rtc_en | input | 1 | Real-time clock enabled |
| wdt_en | input | 1 | Watchdog enabled |
| clk_req | input | NCLK | Pending clock requests, one per clock |
| supply_ack | input | 1 | Supply controller reports stable |
| periph_irq | input | 1 | Wakeup interrupt from an operational peripheral |
| pin_evt | input | NPIN | Pin input events |
| pin_sel0 | input | NPIN | Pin function select bit 0 |
| pin_sel1 | input | NPIN | Pin function select bit 1 |
| pin_ie | input | NPIN | Pin interrupt enables |
| busy | output | 1 | Transition in progress |
| reg_lock | output | 1 | Control and clock register writes locked |
| req_hold | output | 1 | New clock and user reset requests held off |
| supply_req | output | 1 | Request to the supply controller |
| pwr_mode | output | 2 | Power mode: 0 ACTIVE, 1 LP0, 2 LP3, 3 LP4 |
| resume_mode | output | 2 | Active mode to resume after wakeup |
| inv_clk_flag | output | 1 | Sticky invalid-clock flag |
| inv_clk_irq | output | 1 | One-cycle invalid-clock interrupt |

## Verification
The properties take for granted that `supply_ack` is only raised while `supply_req` is high. They also assume the clock-request, force and low-power enable inputs stay steady from the request until the decision. Every bench scenario sets these inputs before it pulses `entry_req`, and raises the acknowledge only after it has seen `supply_req` high. Wakeup sources are driven only once the block has reached a sleep mode, so a wakeup never overlaps a transition.

// File: rtl/lpm_pkg.sv
// Package: shared state and mode encodings for the deep sleep entry sequencer.
// Assumes: nothing; pure type definitions.
package lpm_pkg;

    // Power mode codes seen on the pwr_mode port
    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_LP0    = 2'd1,
        PM_LP3    = 2'd2,
        PM_LP4    = 2'd3
    } pmode_t;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_FREEZE = 3'd1,
        ST_CHECK  = 3'd2,
        ST_SUPPLY = 3'd3,
        ST_DEEP   = 3'd4,
        ST_LIGHT  = 3'd5
    } seq_state_t;

endpackage

// File: rtl/lpm_clk_check.sv
// Module: clock policy check. Flags any pending clock request outside the
// set allowed in deep sleep and picks the deeper variant when both the
// real-time clock and the watchdog are off.
// Assumes: ALLOW_MASK has one bit per clock, 1 meaning allowed in deep sleep.
module lpm_clk_check #(
    parameter int               NCLK       = 5,
    parameter logic [NCLK-1:0]  ALLOW_MASK = 5'b00011
) (
    input  logic [NCLK-1:0] clk_req,
    input  logic            rtc_en,
    input  logic            wdt_en,
    output logic            violation,
    output logic            pick_deeper
);

    logic [NCLK-1:0] bad_req;

    // Per-clock violation: requested but not on the allowed list
    genvar g;
    generate
        for (g = 0; g < NCLK; g++) begin : g_clk
            assign bad_req[g] = clk_req[g] & ~ALLOW_MASK[g];
        end
    endgenerate

    // Reduce violations and decide the deep variant
    always_comb begin
        violation   = |bad_req;
        pick_deeper = ~rtc_en & ~wdt_en;
    end

endmodule

// File: rtl/lpm_wake_qual.sv
// Module: wakeup qualifier. A pin event counts only for pins in plain GPIO
// function with their interrupt enable set; a peripheral interrupt always counts.
// Assumes: pin events are already synchronous to clk.
module lpm_wake_qual #(
    parameter int NPIN = 4
) (
    input  logic [NPIN-1:0] pin_evt,
    input  logic [NPIN-1:0] pin_sel0,
    input  logic [NPIN-1:0] pin_sel1,
    input  logic [NPIN-1:0] pin_ie,
    input  logic            periph_irq,
    output logic            wake
);

    logic [NPIN-1:0] pin_ok;

    // Per-pin qualification
    genvar g;
    generate
        for (g = 0; g < NPIN; g++) begin : g_pin
            assign pin_ok[g] = pin_evt[g] & pin_ie[g] & ~pin_sel0[g] & ~pin_sel1[g];
        end
    endgenerate

    // Combine qualified pins with the peripheral interrupt
    always_comb wake = periph_irq | (|pin_ok);

endmodule

// File: rtl/lpm_flag_reg.sv
// Module: sticky invalid-clock flag with write-one-to-clear and a one-cycle
// interrupt pulse when set while enabled.
// Assumes: set_i is a single-cycle strobe; a set wins over a clear in the same cycle.
module lpm_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);

    // Sticky flag register
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // Interrupt pulse, one cycle per set strobe
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= set_i & ie_i;
    end

endmodule

// File: rtl/lpm_seq_fsm.sv
// Module: entry/exit state machine. Accepts a request only when running,
// freezes registers and requests for the transition, decides at the check
// state, runs the supply handshake and handles wakeup from any sleep state.
// Assumes: violation/pick_deeper are stable while in ST_CHECK.
module lpm_seq_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       entry_req,
    input  logic [1:0] active_mode_id,
    input  logic       force_entry,
    input  logic       inv_clk_ie,
    input  logic       violation,
    input  logic       pick_deeper,
    input  logic       supply_ack,
    input  logic       wake,
    output logic       refuse_strobe,
    output logic       busy,
    output logic       reg_lock,
    output logic       req_hold,
    output logic       supply_req,
    output logic [1:0] pwr_mode,
    output logic [1:0] resume_mode
);

    seq_state_t state_q, state_d;
    pmode_t     deep_q;
    logic [1:0] resume_q;
    logic       refused;

    // Refusal condition evaluated at the check state
    always_comb refused = (state_q == ST_CHECK) && violation && !force_entry;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (entry_req) state_d = ST_FREEZE;
            ST_FREEZE: state_d = ST_CHECK;
            ST_CHECK: begin
                if (refused) state_d = inv_clk_ie ? ST_RUN : ST_LIGHT;
                else         state_d = ST_SUPPLY;
            end
            ST_SUPPLY: if (supply_ack) state_d = ST_DEEP;
            ST_DEEP:   if (wake) state_d = ST_RUN;
            ST_LIGHT:  if (wake) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Capture the active mode identifier when a request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)                                resume_q <= 2'd0;
        else if (state_q == ST_RUN && entry_req)   resume_q <= active_mode_id;
    end

    // Record the deep variant when the check lets entry proceed
    always_ff @(posedge clk) begin
        if (!rst_n)                                deep_q <= PM_LP3;
        else if (state_q == ST_CHECK && !refused)  deep_q <= pick_deeper ? PM_LP4 : PM_LP3;
    end

    // Output decode from state
    always_comb begin
        busy          = (state_q == ST_FREEZE) || (state_q == ST_CHECK) || (state_q == ST_SUPPLY);
        reg_lock      = busy;
        req_hold      = busy;
        supply_req    = (state_q == ST_SUPPLY);
        refuse_strobe = refused;
        resume_mode   = resume_q;
        unique case (state_q)
            ST_DEEP:  pwr_mode = deep_q;
            ST_LIGHT: pwr_mode = PM_LP0;
            default:  pwr_mode = PM_ACTIVE;
        endcase
    end

endmodule

// File: rtl/lpm_entry_seq.sv
// Module: top of the deep sleep entry sequencer. Joins the clock policy
// check, the wakeup qualifier, the sticky flag and the state machine.
// Assumes: all inputs are synchronous to clk; supply_ack only while supply_req.
module lpm_entry_seq #(
    parameter int              NCLK       = 5,
    parameter int              NPIN       = 4,
    parameter logic [NCLK-1:0] ALLOW_MASK = 5'b00011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_req,
    input  logic [1:0]      active_mode_id,
    input  logic            force_entry,
    input  logic            inv_clk_ie,
    input  logic            inv_clk_clr,
    input  logic            rtc_en,
    input  logic            wdt_en,
    input  logic [NCLK-1:0] clk_req,
    input  logic            supply_ack,
    input  logic            periph_irq,
    input  logic [NPIN-1:0] pin_evt,
    input  logic [NPIN-1:0] pin_sel0,
    input  logic [NPIN-1:0] pin_sel1,
    input  logic [NPIN-1:0] pin_ie,
    output logic            busy,
    output logic            reg_lock,
    output logic            req_hold,
    output logic            supply_req,
    output logic [1:0]      pwr_mode,
    output logic [1:0]      resume_mode,
    output logic            inv_clk_flag,
    output logic            inv_clk_irq
);

    logic violation, pick_deeper, wake, refuse_strobe;

    lpm_clk_check #(.NCLK(NCLK), .ALLOW_MASK(ALLOW_MASK)) u_clk_check (
        .clk_req     (clk_req),
        .rtc_en      (rtc_en),
        .wdt_en      (wdt_en),
        .violation   (violation),
        .pick_deeper (pick_deeper)
    );

    lpm_wake_qual #(.NPIN(NPIN)) u_wake (
        .pin_evt    (pin_evt),
        .pin_sel0   (pin_sel0),
        .pin_sel1   (pin_sel1),
        .pin_ie     (pin_ie),
        .periph_irq (periph_irq),
        .wake       (wake)
    );

    lpm_flag_reg u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (refuse_strobe),
        .clr_i  (inv_clk_clr),
        .ie_i   (inv_clk_ie),
        .flag_o (inv_clk_flag),
        .irq_o  (inv_clk_irq)
    );

    lpm_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .entry_req      (entry_req),
        .active_mode_id (active_mode_id),
        .force_entry    (force_entry),
        .inv_clk_ie     (inv_clk_ie),
        .violation      (violation),
        .pick_deeper    (pick_deeper),
        .supply_ack     (supply_ack),
        .wake           (wake),
        .refuse_strobe  (refuse_strobe),
        .busy           (busy),
        .reg_lock       (reg_lock),
        .req_hold       (req_hold),
        .supply_req     (supply_req),
        .pwr_mode       (pwr_mode),
        .resume_mode    (resume_mode)
    );

endmodule

// File: rtl/lpm_entry_seq_chk.sv
// Module: property checker for lpm_entry_seq, attached through bind.
// Assumes: port names match the top module.
module lpm_entry_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       entry_req,
    input logic       busy,
    input logic       reg_lock,
    input logic       req_hold,
    input logic       supply_req,
    input logic       supply_ack,
    input logic       periph_irq,
    input logic [1:0] pwr_mode,
    input logic [1:0] resume_mode,
    input logic       inv_clk_flag,
    input logic       inv_clk_clr,
    input logic       inv_clk_irq
);

    // R1: accepted request freezes registers and requests in the next cycle
    a_r1_freeze_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req && !busy && pwr_mode == 2'd0) |=> (busy && reg_lock && req_hold));

    // R2: captured mode does not move while a transition is running
    a_r2_resume_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(resume_mode));

    // R3: a freshly raised invalid-clock flag never comes with a supply request
    a_r3_no_supply_on_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_clk_flag) |-> !supply_req);

    // R6: supply request only during a busy transition, and held until ack
    a_r6_busy_in_supply: assert property (@(posedge clk) disable iff (!rst_n)
        supply_req |-> busy);
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_req && !supply_ack) |=> supply_req);
    a_r6_deep_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_req && supply_ack) |=> (pwr_mode[1] && !busy && !reg_lock && !req_hold));

    // R8: interrupt pulse lasts one cycle
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        inv_clk_irq |=> !inv_clk_irq);

    // R9: flag stays set until cleared
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_clk_flag && !inv_clk_clr) |=> inv_clk_flag);

    // R10: a peripheral interrupt in any sleep mode returns to active
    a_r10_wake_periph: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode != 2'd0 && periph_irq) |=> (pwr_mode == 2'd0));

endmodule

bind lpm_entry_seq lpm_entry_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .entry_req    (entry_req),
    .busy         (busy),
    .reg_lock     (reg_lock),
    .req_hold     (req_hold),
    .supply_req   (supply_req),
    .supply_ack   (supply_ack),
    .periph_irq   (periph_irq),
    .pwr_mode     (pwr_mode),
    .resume_mode  (resume_mode),
    .inv_clk_flag (inv_clk_flag),
    .inv_clk_clr  (inv_clk_clr),
    .inv_clk_irq  (inv_clk_irq)
);

// File: tb/tb_lpm_entry_seq.sv
`timescale 1ns/1ps
module tb_lpm_entry_seq;

    localparam int NCLK = 5;
    localparam int NPIN = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            entry_req = 1'b0;
    logic [1:0]      active_mode_id = 2'd0;
    logic            force_entry = 1'b0;
    logic            inv_clk_ie = 1'b0;
    logic            inv_clk_clr = 1'b0;
    logic            rtc_en = 1'b1;
    logic            wdt_en = 1'b1;
    logic [NCLK-1:0] clk_req = '0;
    logic            supply_ack = 1'b0;
    logic            periph_irq = 1'b0;
    logic [NPIN-1:0] pin_evt = '0;
    logic [NPIN-1:0] pin_sel0 = '0;
    logic [NPIN-1:0] pin_sel1 = '0;
    logic [NPIN-1:0] pin_ie = '0;
    logic            busy, reg_lock, req_hold, supply_req;
    logic [1:0]      pwr_mode, resume_mode;
    logic            inv_clk_flag, inv_clk_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lpm_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .active_mode_id(active_mode_id),
        .force_entry(force_entry), .inv_clk_ie(inv_clk_ie), .inv_clk_clr(inv_clk_clr),
        .rtc_en(rtc_en), .wdt_en(wdt_en), .clk_req(clk_req), .supply_ack(supply_ack),
        .periph_irq(periph_irq), .pin_evt(pin_evt), .pin_sel0(pin_sel0), .pin_sel1(pin_sel1),
        .pin_ie(pin_ie), .busy(busy), .reg_lock(reg_lock), .req_hold(req_hold),
        .supply_req(supply_req), .pwr_mode(pwr_mode), .resume_mode(resume_mode),
        .inv_clk_flag(inv_clk_flag), .inv_clk_irq(inv_clk_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse a request; returns after the accepting edge, then waits to the decision edge
    task automatic request(input logic [1:0] id);
        @(negedge clk); entry_req = 1'b1; active_mode_id = id;
        @(negedge clk); entry_req = 1'b0;
        chk("R1 busy", busy, 1); chk("R1 reg_lock", reg_lock, 1); chk("R1 req_hold", req_hold, 1);
        chk("R1 resume_mode", resume_mode, id);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ack_supply();
        supply_ack = 1'b1;
        @(negedge clk); supply_ack = 1'b0;
    endtask

    task automatic wake_periph();
        periph_irq = 1'b1;
        @(negedge clk); periph_irq = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 pwr_mode", pwr_mode, 0); chk("R12 busy", busy, 0);
        chk("R12 reg_lock", reg_lock, 0); chk("R12 req_hold", req_hold, 0);
        chk("R12 supply_req", supply_req, 0); chk("R12 flag", inv_clk_flag, 0);
        chk("R12 irq", inv_clk_irq, 0);
    endtask

    // Allowed clocks only, RTC on: LP3, then peripheral wakeup
    task automatic t_lp3_entry();
        clk_req = 5'b00011; rtc_en = 1'b1; wdt_en = 1'b0;
        request(2'd2);
        chk("R4 supply_req", supply_req, 1); chk("R4 flag", inv_clk_flag, 0);
        repeat (5) @(negedge clk);
        chk("R6 supply_req held", supply_req, 1); chk("R6 busy held", busy, 1);
        ack_supply();
        chk("R5 LP3 code", pwr_mode, 2); chk("R6 busy low", busy, 0);
        chk("R6 lock low", reg_lock, 0); chk("R6 hold low", req_hold, 0);
        chk("R6 supply_req low", supply_req, 0);
        active_mode_id = 2'd0;
        wake_periph();
        chk("R10 active", pwr_mode, 0); chk("R10 resume", resume_mode, 2);
    endtask

    // RTC and WDT off: LP4; a second request during supply is ignored; pin wake
    task automatic t_lp4_entry();
        clk_req = 5'b00001; rtc_en = 1'b0; wdt_en = 1'b0;
        request(2'd1);
        @(negedge clk); entry_req = 1'b1; active_mode_id = 2'd3;
        @(negedge clk); entry_req = 1'b0;
        chk("R2 resume kept", resume_mode, 1);
        ack_supply();
        chk("R5 LP4 code", pwr_mode, 3);
        entry_req = 1'b1; active_mode_id = 2'd3;
        @(negedge clk); entry_req = 1'b0;
        chk("R2 sleep ignores req", pwr_mode, 3); chk("R2 sleep busy", busy, 0);
        pin_sel0 = 4'b0000; pin_sel1 = 4'b0000; pin_ie = 4'b0100; pin_evt = 4'b0100;
        @(negedge clk); pin_evt = '0;
        chk("R11 qualified pin wakes", pwr_mode, 0); chk("R10 resume", resume_mode, 1);
    endtask

    // Violation, no force, IE off: LP0; unqualified pins ignored; flag sticky
    task automatic t_refuse_lp0();
        clk_req = 5'b01001; force_entry = 1'b0; inv_clk_ie = 1'b0; rtc_en = 1'b0; wdt_en = 1'b0;
        request(2'd3);
        chk("R3 flag", inv_clk_flag, 1); chk("R3 no supply", supply_req, 0);
        chk("R7 LP0", pwr_mode, 1); chk("R7 busy", busy, 0);
        repeat (3) @(negedge clk);
        chk("R3 never supply", supply_req, 0);
        pin_ie = 4'b0010; pin_sel0 = 4'b0010; pin_evt = 4'b0010;
        @(negedge clk); pin_evt = '0;
        chk("R11 sel0 set ignored", pwr_mode, 1);
        pin_sel0 = '0; pin_sel1 = 4'b0010; pin_evt = 4'b0010;
        @(negedge clk); pin_evt = '0;
        chk("R11 sel1 set ignored", pwr_mode, 1);
        pin_sel1 = '0; pin_ie = '0; pin_evt = 4'b0010;
        @(negedge clk); pin_evt = '0;
        chk("R11 ie off ignored", pwr_mode, 1);
        wake_periph();
        chk("R10 LP0 wake", pwr_mode, 0); chk("R10 resume", resume_mode, 3);
        repeat (2) @(negedge clk);
        chk("R9 flag sticky", inv_clk_flag, 1);
        inv_clk_clr = 1'b1;
        @(negedge clk); inv_clk_clr = 1'b0;
        chk("R9 flag cleared", inv_clk_flag, 0);
    endtask

    // Violation with IE on: interrupt pulse and direct return to active
    task automatic t_refuse_irq();
        clk_req = 5'b10000; force_entry = 1'b0; inv_clk_ie = 1'b1;
        request(2'd0);
        chk("R8 irq high", inv_clk_irq, 1); chk("R8 active", pwr_mode, 0);
        chk("R8 busy low", busy, 0); chk("R3 flag", inv_clk_flag, 1);
        @(negedge clk);
        chk("R8 irq one cycle", inv_clk_irq, 0);
        inv_clk_clr = 1'b1;
        @(negedge clk); inv_clk_clr = 1'b0;
        chk("R9 flag cleared", inv_clk_flag, 0);
    endtask

    // Violation overridden by force: proceeds, flag clear
    task automatic t_force();
        clk_req = 5'b00100; force_entry = 1'b1; inv_clk_ie = 1'b1; rtc_en = 1'b1; wdt_en = 1'b1;
        request(2'd2);
        chk("R4 forced supply", supply_req, 1); chk("R4 flag clear", inv_clk_flag, 0);
        chk("R4 no irq", inv_clk_irq, 0);
        ack_supply();
        chk("R5 LP3 code", pwr_mode, 2);
        wake_periph();
        chk("R10 active", pwr_mode, 0);
        force_entry = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_lp3_entry();
        t_lp4_entry();
        t_refuse_lp0();
        t_refuse_irq();
        t_force();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule